// File: doc/BRIEF.md
# Temperature-Compensation Lookup Sequencer

This block closes the digital half of an adaptive modulation loop for a laser driver. While the auto-monitor input is high, it starts a measurement at a fixed, selectable interval. The measurement is either the laser bias current or the current from an external temperature sensor. The raw 12-bit reading is held for the length of a conversion. It then passes through a programmable window: a coarse offset is removed, and the remaining span is stretched onto an 8-bit code.

That code addresses a 256-entry compensation table, which sits outside the block as a synchronous RAM. The byte the table returns is written into the modulation DAC register on the following cycle. In this way, modulation current follows laser temperature or bias current along any curve that has been stored in the table.

A ready output goes low while a conversion runs. A one-cycle strobe marks each fresh code. Dropping the auto-monitor input halts the loop at once: the interval timer, any running conversion and any pending write-back are all cancelled.

Top module: `modcomp_sequencer`

## Requirements
- R1: With auto-monitor high and the interval field steady, conversions start every N cycles. N is the interval in microseconds multiplied by `CYC_PER_US`. The field code sets the interval as follows: 0→5, 1→20, 2→160, 3→1280, 4→6250, 5→25000, 6→200000, 7→1600000 µs.
- R2: The interval timer restarts from zero whenever the interval field changes and whenever auto-monitor is low. The first conversion after auto-monitor rises, or after a field change, starts N cycles after that cycle.
- R3: `srcSel` = 0 samples `biasRaw`, and `srcSel` = 1 samples `tempRaw`. The sample is taken in the cycle the conversion starts.
- R4: `offsetSel` removes k·1024 from the held reading, where k is the field value 0..3. A result below zero becomes 0.
- R5: Let d be the reading after the offset is removed. `spanSel` sets the code as follows: 0 gives floor(d·5/8) (a tenth of full scale), 1 gives floor(d/4), 2 gives floor(d/8), and 3 gives floor(d/16). Any code above 255 saturates to 255. For example, span 1 with offset 3 maps readings 3072..4095 onto codes 0..255.
- R6: `rdyN` is low for exactly `CONV_CYC` cycles per conversion. In the next cycle, `convValid` is high for one cycle and `convCode` holds the new code.
- R7: `tblRdEn` is high with `tblRdAddr` = `convCode` in the `convValid` cycle. One cycle later, `dacWrEn` is high and `dacWrData` carries the table byte.
- R8: While auto-monitor is low, `tblRdEn` and `dacWrEn` stay low. A running conversion is cancelled, so `rdyN` is high from the next cycle.
- R9: After reset, `rdyN` = 1, `convValid` = 0, `convCode` = 0, `tblRdEn` = 0 and `dacWrEn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoMon | input | 1 | Enables the compensation loop |
| srcSel | input | 1 | Measurement source: 0 bias, 1 temperature |
| intervalSel | input | 3 | Sample interval code |
| spanSel | input | 2 | Span scaling code |
| offsetSel | input | 2 | Offset code |
| biasRaw | input | RAW_W | Raw bias-current reading |
| tempRaw | input | RAW_W | Raw temperature-sensor reading |
| tblRdEn | output | 1 | Table read request |
| tblRdAddr | output | 8 | Table read address |
| tblRdData | input | 8 | Table data, one cycle after the request |
| dacWrEn | output | 1 | Modulation DAC register write |
| dacWrData | output | 8 | Value written to the DAC register |
| rdyN | output | 1 | Low while a conversion runs |
| convValid | output | 1 | One-cycle strobe for a new code |
| convCode | output | 8 | Most recent windowed code |

## Verification
Two functions can land in the same cycle. When the interval is only one cycle longer than a conversion, the next conversion can start in the cycle where the table is read. Its first busy cycle then coincides with the DAC write for the previous code. The bench provokes this by running the shortest interval with a 1-cycle-per-microsecond timer and a 4-cycle conversion. A behavioural model, compared on every clock, checks that the write carries the byte for the earlier code while the new sample is already held. A second overlap comes from dropping auto-monitor during the strobe cycle or the write cycle, which must suppress the pending read or write.

// File: rtl/modcomp_pkg.sv
package modcomp_pkg;

  localparam int CODE_W = 8;

  // Strobes from the sequencing control into the datapath.
  typedef struct packed {
    logic capture;   // hold the selected raw reading
    logic finish;    // register the windowed code
  } ctrlStrobes_t;

  // Sample interval in microseconds for each interval code.
  function automatic int unsigned intervalUs(input logic [2:0] sel);
    case (sel)
      3'd0:    intervalUs = 5;
      3'd1:    intervalUs = 20;
      3'd2:    intervalUs = 160;
      3'd3:    intervalUs = 1280;
      3'd4:    intervalUs = 6250;
      3'd5:    intervalUs = 25000;
      3'd6:    intervalUs = 200000;
      default: intervalUs = 1600000;
    endcase
  endfunction

endpackage

// File: rtl/modcomp_ctrl.sv
module modcomp_ctrl
  import modcomp_pkg::*;
#(
  parameter int CYC_PER_US = 250,
  parameter int CONV_CYC   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         autoMon,
  input  logic [2:0]   intervalSel,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         valid,
  output logic         pend
);

  localparam int CNT_W  = $clog2(1600000 * CYC_PER_US + 1);
  localparam int CONV_W = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lastCnt;
  logic [31:0]       cyclesFull;
  logic [2:0]        prevSel;
  logic [CONV_W-1:0] left;
  logic              selChange;
  logic              tick;

  always_comb begin
    cyclesFull = intervalUs(intervalSel) * CYC_PER_US;
    lastCnt    = cyclesFull[CNT_W-1:0] - CNT_W'(1);
    selChange  = (intervalSel != prevSel);
    tick       = autoMon && !selChange && (cnt == lastCnt);
    strobes.capture = tick && !busy;
    strobes.finish  = autoMon && busy && (left == '0);
  end

  // Interval timer: restarts on field change or loop disable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      prevSel <= '0;
    end else begin
      prevSel <= intervalSel;
      if (!autoMon || selChange)
        cnt <= '0;
      else if (cnt == lastCnt)
        cnt <= '0;
      else
        cnt <= cnt + CNT_W'(1);
    end
  end

  // Conversion sequencing and write-back pipeline.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      left  <= '0;
      valid <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pend <= valid && autoMon;
      if (!autoMon) begin
        busy  <= 1'b0;
        valid <= 1'b0;
      end else if (busy) begin
        valid <= (left == '0);
        if (left == '0)
          busy <= 1'b0;
        else
          left <= left - CONV_W'(1);
      end else begin
        valid <= 1'b0;
        if (tick) begin
          busy <= 1'b1;
          left <= CONV_W'(CONV_CYC - 1);
        end
      end
    end
  end

endmodule

// File: rtl/modcomp_path.sv
module modcomp_path
  import modcomp_pkg::*;
#(
  parameter int RAW_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              srcSel,
  input  logic [1:0]        spanSel,
  input  logic [1:0]        offsetSel,
  input  logic [RAW_W-1:0]  biasRaw,
  input  logic [RAW_W-1:0]  tempRaw,
  output logic [CODE_W-1:0] codeReg
);

  localparam int WIDE_W = RAW_W + 3;
  localparam logic [WIDE_W-1:0] FIVE = WIDE_W'(5);

  logic [RAW_W-1:0]  heldRaw;
  logic [RAW_W-1:0]  offsetVal;
  logic [RAW_W-1:0]  diffVal;
  logic [WIDE_W-1:0] diffWide;
  logic [WIDE_W-1:0] scaled [4];
  logic [WIDE_W-1:0] picked;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    offsetVal = RAW_W'(offsetSel) << (RAW_W - 2);
    diffVal   = (heldRaw >= offsetVal) ? (heldRaw - offsetVal) : '0;
    diffWide  = {3'b000, diffVal};
  end

  // One scaler per span code; the tenth span needs a x5/8 step.
  for (genvar g = 0; g < 4; g++) begin : gSpan
    if (g == 0) begin : gTenth
      assign scaled[g] = (diffWide * FIVE) >> (RAW_W - 9);
    end else begin : gShift
      assign scaled[g] = diffWide >> (RAW_W - 8 - (3 - g));
    end
  end

  always_comb begin
    picked   = scaled[spanSel];
    codeNext = (|picked[WIDE_W-1:CODE_W]) ? '1 : picked[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldRaw <= '0;
      codeReg <= '0;
    end else begin
      if (strobes.capture)
        heldRaw <= srcSel ? tempRaw : biasRaw;
      if (strobes.finish)
        codeReg <= codeNext;
    end
  end

endmodule

// File: rtl/modcomp_sequencer.sv
module modcomp_sequencer
  import modcomp_pkg::*;
#(
  parameter int RAW_W      = 12,
  parameter int CYC_PER_US = 250,
  parameter int CONV_CYC   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoMon,
  input  logic             srcSel,
  input  logic [2:0]       intervalSel,
  input  logic [1:0]       spanSel,
  input  logic [1:0]       offsetSel,
  input  logic [RAW_W-1:0] biasRaw,
  input  logic [RAW_W-1:0] tempRaw,
  output logic             tblRdEn,
  output logic [7:0]       tblRdAddr,
  input  logic [7:0]       tblRdData,
  output logic             dacWrEn,
  output logic [7:0]       dacWrData,
  output logic             rdyN,
  output logic             convValid,
  output logic [7:0]       convCode
);

  ctrlStrobes_t      strobes;
  logic              busy;
  logic              valid;
  logic              pend;
  logic [CODE_W-1:0] codeReg;

  modcomp_ctrl #(
    .CYC_PER_US (CYC_PER_US),
    .CONV_CYC   (CONV_CYC)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .autoMon     (autoMon),
    .intervalSel (intervalSel),
    .strobes     (strobes),
    .busy        (busy),
    .valid       (valid),
    .pend        (pend)
  );

  modcomp_path #(
    .RAW_W (RAW_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcSel    (srcSel),
    .spanSel   (spanSel),
    .offsetSel (offsetSel),
    .biasRaw   (biasRaw),
    .tempRaw   (tempRaw),
    .codeReg   (codeReg)
  );

  assign rdyN      = !busy;
  assign convValid = valid;
  assign convCode  = codeReg;
  assign tblRdEn   = valid && autoMon;
  assign tblRdAddr = codeReg;
  assign dacWrEn   = pend && autoMon;
  assign dacWrData = tblRdData;

endmodule

// File: rtl/modcomp_sequencer_chk.sv
module modcomp_sequencer_chk #(
  parameter int CONV_CYC = 8
) (
  input logic clk,
  input logic rstN,
  input logic autoMon,
  input logic rdyN,
  input logic convValid,
  input logic tblRdEn,
  input logic dacWrEn
);

  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      runLen <= '0;
    else
      runLen <= rdyN ? 16'd0 : runLen + 16'd1;
  end

  // R6: each strobe follows a busy run of exactly CONV_CYC cycles
  assert_conv_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    convValid |-> (runLen == 16'(CONV_CYC)));

  // R7: the DAC write lands one cycle after the table read
  assert_wr_after_rd_R7: assert property (@(posedge clk) disable iff (!rstN)
    dacWrEn |-> $past(tblRdEn));

  // R7: a table read only follows the last busy cycle
  assert_rd_after_conv_R7: assert property (@(posedge clk) disable iff (!rstN)
    tblRdEn |-> $past(!rdyN));

  // R8: loop disabled means no table or DAC traffic
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !autoMon |-> (!tblRdEn && !dacWrEn));

  // R8: a running conversion is cancelled within one cycle
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    !autoMon |=> rdyN);

endmodule

bind modcomp_sequencer modcomp_sequencer_chk #(.CONV_CYC(CONV_CYC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .autoMon   (autoMon),
  .rdyN      (rdyN),
  .convValid (convValid),
  .tblRdEn   (tblRdEn),
  .dacWrEn   (dacWrEn)
);

// File: tb/tb_modcomp_sequencer.sv
`timescale 1ns/1ps
module tb_modcomp_sequencer;

  localparam int RAW_W = 12;
  localparam int CPU   = 1;
  localparam int CONV  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             autoMon = 1'b0;
  logic             srcSel = 1'b0;
  logic [2:0]       intervalSel = 3'd0;
  logic [1:0]       spanSel = 2'd3;
  logic [1:0]       offsetSel = 2'd0;
  logic [RAW_W-1:0] biasRaw = '0;
  logic [RAW_W-1:0] tempRaw = '0;
  logic             tblRdEn;
  logic [7:0]       tblRdAddr;
  logic [7:0]       tblRdData = 8'd0;
  logic             dacWrEn;
  logic [7:0]       dacWrData;
  logic             rdyN;
  logic             convValid;
  logic [7:0]       convCode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] mem [256];
  int usTab [8];

  modcomp_sequencer #(.RAW_W(RAW_W), .CYC_PER_US(CPU), .CONV_CYC(CONV)) dut (
    .clk(clk), .rstN(rstN), .autoMon(autoMon), .srcSel(srcSel),
    .intervalSel(intervalSel), .spanSel(spanSel), .offsetSel(offsetSel),
    .biasRaw(biasRaw), .tempRaw(tempRaw), .tblRdEn(tblRdEn),
    .tblRdAddr(tblRdAddr), .tblRdData(tblRdData), .dacWrEn(dacWrEn),
    .dacWrData(dacWrData), .rdyN(rdyN), .convValid(convValid),
    .convCode(convCode)
  );

  always #2 clk = ~clk;

  initial begin
    usTab = '{5, 20, 160, 1280, 6250, 25000, 200000, 1600000};
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
  end

  // Table RAM with one cycle of read latency.
  always @(posedge clk) if (tblRdEn) tblRdData <= mem[tblRdAddr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int windowCode(input int raw, input int sp, input int of);
    int d, den, c;
    d = raw - of * 1024;
    if (d < 0) d = 0;
    den = (sp == 0) ? 10 : (sp == 1) ? 4 : (sp == 2) ? 2 : 1;
    c = (d * 256 * den) / 4096;
    return (c > 255) ? 255 : c;
  endfunction

  // Behavioural reference, advanced on each rising edge.
  int mCnt, mPrev, mBusy, mLeft, mHeld, mValid, mCode, mPend, mPendAddr;
  always @(posedge clk) begin
    int n; bit chg, tk;
    if (!rstN) begin
      mCnt = 0; mPrev = 0; mBusy = 0; mLeft = 0; mHeld = 0;
      mValid = 0; mCode = 0; mPend = 0; mPendAddr = 0;
    end else begin
      n   = usTab[intervalSel] * CPU;
      chg = (int'(intervalSel) != mPrev);
      tk  = autoMon && !chg && (mCnt == n - 1);
      mPrev = intervalSel;
      mPend = mValid && autoMon;
      mPendAddr = mCode;
      if (!autoMon) begin
        mBusy = 0; mValid = 0;
      end else if (mBusy) begin
        if (mLeft == 0) begin
          mBusy = 0; mValid = 1;
          mCode = windowCode(mHeld, spanSel, offsetSel);
        end else begin
          mLeft--; mValid = 0;
        end
      end else begin
        mValid = 0;
        if (tk) begin
          mBusy = 1; mLeft = CONV - 1;
          mHeld = srcSel ? tempRaw : biasRaw;
        end
      end
      if (!autoMon || chg || mCnt == n - 1) mCnt = 0; else mCnt++;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eRd, eWr;
      eRd = mValid && autoMon;
      eWr = mPend && autoMon;
      check(rdyN == !mBusy, "R1 R2 R6 R8 rdyN", rdyN, !mBusy);
      check(convValid == mValid, "R6 convValid", convValid, mValid);
      check(convCode == mCode, "R3 R4 R5 convCode", convCode, mCode);
      check(tblRdEn == eRd, "R7 R8 tblRdEn", tblRdEn, eRd);
      check(dacWrEn == eWr, "R7 R8 dacWrEn", dacWrEn, eWr);
      if (eRd) check(tblRdAddr == mCode, "R7 tblRdAddr", tblRdAddr, mCode);
      if (eWr) check(dacWrData == mem[mPendAddr], "R7 dacWrData", dacWrData, mem[mPendAddr]);
    end
  end

  int pickIdx = 0;
  function automatic logic [11:0] pickRaw(input int k);
    int edges [12] = '{0, 1023, 1024, 2047, 2048, 3071, 3072, 4095, 409, 410, 3481, 1};
    if (k % 3 == 0) return 12'(edges[(k / 3) % 12]);
    return 12'($urandom % 4096);
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      biasRaw = pickRaw(pickIdx);
      tempRaw = pickRaw(pickIdx + 7);
      pickIdx++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(rdyN == 1'b1, "R9 rdyN", rdyN, 1);
    check(convValid == 1'b0, "R9 convValid", convValid, 0);
    check(convCode == 8'd0, "R9 convCode", convCode, 0);
    check(tblRdEn == 1'b0, "R9 tblRdEn", tblRdEn, 0);
    check(dacWrEn == 1'b0, "R9 dacWrEn", dacWrEn, 0);
    @(posedge clk); #1 rstN = 1'b1;
    run(5);
    // R8: loop disabled, nothing moves
    autoMon = 1'b0; run(20);
    autoMon = 1'b1; run(60);
    // R4 R5: every span/offset combination
    for (int sp = 0; sp < 4; sp++)
      for (int of = 0; of < 4; of++) begin
        spanSel = 2'(sp); offsetSel = 2'(of); run(25);
      end
    // R3: temperature source
    srcSel = 1'b1; run(40); srcSel = 1'b0;
    // R5: quarter span with three-quarter offset
    spanSel = 2'd1; offsetSel = 2'd3; run(40);
    // R1 R2: longer intervals, changes mid-count
    intervalSel = 3'd1; run(70);
    intervalSel = 3'd2; run(100);
    intervalSel = 3'd1; run(50);
    intervalSel = 3'd3; run(1400);
    intervalSel = 3'd0; run(30);
    // R8: drop the loop at every phase of a conversion
    for (int i = 0; i < 30; i++) begin
      autoMon = 1'b1; run(i % 7 + 1);
      autoMon = 1'b0; run(1 + (i % 2));
    end
    autoMon = 1'b1; run(50);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule